// File: doc/BRIEF.md
# Dual-Section Latched Bus Transceiver

This block links two 16-bit ports, A and B, as two independent 8-bit sections. Each section holds one storage latch per direction: one stores data seen on A for presentation on B, the other stores data seen on B for presentation on A. Every direction of every section has three active-low controls of its own: a gate (chip enable), a latch enable and a drive enable. The two sections share nothing but the clock and reset, so they work either as two 8-bit transceivers or, with their controls tied together, as one 16-bit transceiver.

The design runs in a clocked environment. A latch is open while both its gate and its latch enable are low. While open, its output follows the source port combinationally, and its storage register reloads from the source on every clock edge. When the latch enable goes high, or the gate goes high, the storage keeps the source value taken at the last edge on which the latch was open. Three-state pins are modelled as a driven value plus a per-bit drive enable. An undriven bit shows value 0 and enable 0.

Top module: `tcv_dual_top`

## Requirements
- R1: While a section's A-to-B gate, latch enable and drive enable are all low, its B slice equals its A slice in the same cycle, with no clock edge in between.
- R2: At every rising clock edge where a section's A-to-B gate and latch enable are both low, its A-to-B storage loads the A slice. After the latch enable rises, the storage keeps the value loaded at the last such edge.
- R3: While a section's A-to-B gate is high, its storage keeps its content whatever the latch enable and port A do.
- R4: A section's B slice is driven (all eight b_oe bits 1) exactly when its A-to-B gate and drive enable are both low. Otherwise all eight b_oe bits are 0 and the b_out slice is 0.
- R5: With the A-to-B gate low, the latch enable high and the drive enable low, the B slice shows the stored value, and changes on A do not reach it.
- R6: The drive enable has no effect on the stored content. A value kept with the drive off appears unchanged when the drive is later turned on, with no new load.
- R7: The B-to-A direction obeys R1 to R6 with its own gate, latch enable and drive enable, loading from B and driving A.
- R8: Section 0 owns bits 7:0 and control bit 0, and section 1 owns bits 15:8 and control bit 1. Controls or data of one section never change the other section's outputs or storage.
- R9: An active-low reset clears all four storages to 0. After reset, with every control high, no pin is driven.
- R10: When both drive enables of a section are low at once, A is driven from the B-to-A storage path and B from the A-to-B storage path, each independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage registers |
| rst_n | input | 1 | Asynchronous active-low reset, clears storage |
| ce_ab_n | input | 2 | A-to-B gate, one bit per section, active low |
| le_ab_n | input | 2 | A-to-B latch enable, one bit per section, active low |
| oe_ab_n | input | 2 | B drive enable, one bit per section, active low |
| ce_ba_n | input | 2 | B-to-A gate, one bit per section, active low |
| le_ba_n | input | 2 | B-to-A latch enable, one bit per section, active low |
| oe_ba_n | input | 2 | A drive enable, one bit per section, active low |
| a_in | input | 16 | Value seen on port A |
| b_in | input | 16 | Value seen on port B |
| a_out | output | 16 | Value driven onto port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_out | output | 16 | Value driven onto port B |
| b_oe | output | 16 | Per-bit drive enable for port B |

## Verification
Drive enables and values in the open state are combinational, so they are due in the same cycle as the control or data change. Stored values change one rising edge after the stimulus. The bench changes inputs one time unit after a falling edge and compares every output pin at the next falling edge plus one unit. That point lies after exactly one rising edge, so combinational results and the single storage update are both settled. A bench model of the four storages updates at that same rising edge, and the expected pin values are computed from that model.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

    // Active-low control set for one direction of one section.
    typedef struct packed {
        logic ce_n;   // gate: low allows loading and driving
        logic le_n;   // latch enable: low keeps the latch open
        logic oe_n;   // drive enable: low drives the far port
    } dir_ctl_t;

    function automatic logic latch_open(input dir_ctl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic drive_on(input dir_ctl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/tcv_latch_dir.sv
module tcv_latch_dir
    import tcv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] drv_val,
    output logic         drv_en,
    output logic [W-1:0] store_o
);

    typedef struct packed {
        logic [W-1:0] store;
    } st_t;

    st_t          st_d, st_q;
    logic         open_w;
    logic [W-1:0] lat_out;

    always_comb begin
        st_d    = st_q;
        open_w  = latch_open(ctl);
        if (open_w) begin
            st_d.store = src;
        end
        lat_out = open_w ? src : st_q.store;
        drv_en  = drive_on(ctl);
        drv_val = drv_en ? lat_out : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign store_o = st_q.store;

endmodule

// File: rtl/tcv_section.sv
module tcv_section
    import tcv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctl_t     ab_ctl,
    input  dir_ctl_t     ba_ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] ab_store,
    output logic [W-1:0] ba_store
);

    logic ab_en, ba_en;

    // A side feeds the latch that drives B
    tcv_latch_dir #(.W(W)) u_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ab_ctl),
        .src     (a_in),
        .drv_val (b_out),
        .drv_en  (ab_en),
        .store_o (ab_store)
    );

    // B side feeds the latch that drives A
    tcv_latch_dir #(.W(W)) u_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ba_ctl),
        .src     (b_in),
        .drv_val (a_out),
        .drv_en  (ba_en),
        .store_o (ba_store)
    );

    assign b_oe = {W{ab_en}};
    assign a_oe = {W{ba_en}};

endmodule

// File: rtl/tcv_dual_top.sv
module tcv_dual_top
    import tcv_pkg::*;
#(
    parameter int SECT_W = 8,
    parameter int N_SECT = 2,
    localparam int BUS_W = SECT_W * N_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SECT-1:0] ce_ab_n,
    input  logic [N_SECT-1:0] le_ab_n,
    input  logic [N_SECT-1:0] oe_ab_n,
    input  logic [N_SECT-1:0] ce_ba_n,
    input  logic [N_SECT-1:0] le_ba_n,
    input  logic [N_SECT-1:0] oe_ba_n,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  a_oe,
    output logic [BUS_W-1:0]  b_out,
    output logic [BUS_W-1:0]  b_oe
);

    logic [BUS_W-1:0] ab_store;
    logic [BUS_W-1:0] ba_store;

    for (genvar k = 0; k < N_SECT; k++) begin : g_sect
        dir_ctl_t ab_c, ba_c;

        always_comb begin
            ab_c = '{ce_n: ce_ab_n[k], le_n: le_ab_n[k], oe_n: oe_ab_n[k]};
            ba_c = '{ce_n: ce_ba_n[k], le_n: le_ba_n[k], oe_n: oe_ba_n[k]};
        end

        tcv_section #(.W(SECT_W)) u_sect (
            .clk      (clk),
            .rst_n    (rst_n),
            .ab_ctl   (ab_c),
            .ba_ctl   (ba_c),
            .a_in     (a_in [k*SECT_W +: SECT_W]),
            .b_in     (b_in [k*SECT_W +: SECT_W]),
            .a_out    (a_out[k*SECT_W +: SECT_W]),
            .a_oe     (a_oe [k*SECT_W +: SECT_W]),
            .b_out    (b_out[k*SECT_W +: SECT_W]),
            .b_oe     (b_oe [k*SECT_W +: SECT_W]),
            .ab_store (ab_store[k*SECT_W +: SECT_W]),
            .ba_store (ba_store[k*SECT_W +: SECT_W])
        );
    end

endmodule

// File: rtl/tcv_dual_chk.sv
module tcv_dual_chk #(
    parameter int SECT_W = 8,
    parameter int N_SECT = 2,
    localparam int BUS_W = SECT_W * N_SECT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SECT-1:0] ce_ab_n,
    input logic [N_SECT-1:0] le_ab_n,
    input logic [N_SECT-1:0] oe_ab_n,
    input logic [N_SECT-1:0] ce_ba_n,
    input logic [N_SECT-1:0] le_ba_n,
    input logic [N_SECT-1:0] oe_ba_n,
    input logic [BUS_W-1:0]  a_in,
    input logic [BUS_W-1:0]  b_in,
    input logic [BUS_W-1:0]  a_out,
    input logic [BUS_W-1:0]  a_oe,
    input logic [BUS_W-1:0]  b_out,
    input logic [BUS_W-1:0]  b_oe,
    input logic [BUS_W-1:0]  ab_store,
    input logic [BUS_W-1:0]  ba_store
);

    for (genvar k = 0; k < N_SECT; k++) begin : g_chk
        localparam int LO = k * SECT_W;

        a_r1_ab_flow: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[k] && !le_ab_n[k] && !oe_ab_n[k]) |->
                b_out[LO +: SECT_W] == a_in[LO +: SECT_W]);

        a_r2_ab_load: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[k] && !le_ab_n[k]) |=>
                ab_store[LO +: SECT_W] == $past(a_in[LO +: SECT_W]));

        a_r3_ab_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ce_ab_n[k] |=> $stable(ab_store[LO +: SECT_W]));

        a_r4_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_ab_n[k] || oe_ab_n[k]) |->
                (b_oe[LO +: SECT_W] == '0 && b_out[LO +: SECT_W] == '0));

        a_r4_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[k] && !oe_ab_n[k]) |-> b_oe[LO +: SECT_W] == '1);

        a_r5_ab_stored: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[k] && le_ab_n[k] && !oe_ab_n[k]) |->
                b_out[LO +: SECT_W] == ab_store[LO +: SECT_W]);

        a_r6_ab_le_hold: assert property (@(posedge clk) disable iff (!rst_n)
            le_ab_n[k] |=> $stable(ab_store[LO +: SECT_W]));

        a_r7_ba_flow: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ba_n[k] && !le_ba_n[k] && !oe_ba_n[k]) |->
                a_out[LO +: SECT_W] == b_in[LO +: SECT_W]);

        a_r7_ba_load: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ba_n[k] && !le_ba_n[k]) |=>
                ba_store[LO +: SECT_W] == $past(b_in[LO +: SECT_W]));

        a_r7_ba_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_ba_n[k] || le_ba_n[k]) |=> $stable(ba_store[LO +: SECT_W]));

        a_r7_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_ba_n[k] || oe_ba_n[k]) |->
                (a_oe[LO +: SECT_W] == '0 && a_out[LO +: SECT_W] == '0));

        a_r7_ba_stored: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ba_n[k] && le_ba_n[k] && !oe_ba_n[k]) |->
                a_out[LO +: SECT_W] == ba_store[LO +: SECT_W]);
    end

endmodule

bind tcv_dual_top tcv_dual_chk #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_chk (.*);

// File: tb/tb_tcv_dual_top.sv
module tb_tcv_dual_top;

    localparam int SW = 8;
    localparam int NS = 2;
    localparam int BW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
    logic [NS-1:0] ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int failures = 0;
    int clashes = 0;

    // bench model of the four storages
    logic [SW-1:0] m_ab [NS];
    logic [SW-1:0] m_ba [NS];

    always #5 clk = ~clk;

    tcv_dual_top #(.SECT_W(SW), .N_SECT(NS)) dut (
        .clk(clk), .rst_n(rst_n),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        for (int k = 0; k < NS; k++) begin
            if (!rst_n) begin
                m_ab[k] <= '0;
                m_ba[k] <= '0;
            end else begin
                if (!ce_ab_n[k] && !le_ab_n[k]) m_ab[k] <= a_in[k*SW +: SW];
                if (!ce_ba_n[k] && !le_ba_n[k]) m_ba[k] <= b_in[k*SW +: SW];
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare every output pin against values derived from the model
    task automatic compare_all(input string req);
        logic [BW-1:0] ea, eae, eb, ebe;
        for (int k = 0; k < NS; k++) begin
            logic [SW-1:0] lat;
            logic          on;
            lat = (!ce_ab_n[k] && !le_ab_n[k]) ? a_in[k*SW +: SW] : m_ab[k];
            on  = !ce_ab_n[k] && !oe_ab_n[k];
            eb [k*SW +: SW] = on ? lat : '0;
            ebe[k*SW +: SW] = {SW{on}};
            lat = (!ce_ba_n[k] && !le_ba_n[k]) ? b_in[k*SW +: SW] : m_ba[k];
            on  = !ce_ba_n[k] && !oe_ba_n[k];
            ea [k*SW +: SW] = on ? lat : '0;
            eae[k*SW +: SW] = {SW{on}};
            if (!oe_ab_n[k] && !ce_ab_n[k] && !oe_ba_n[k] && !ce_ba_n[k]) begin
                clashes++;
                $display("NOTE bus contention in section %0d", k);
            end
        end
        chk(req, "a_out", a_out, ea);
        chk(req, "a_oe",  a_oe,  eae);
        chk(req, "b_out", b_out, eb);
        chk(req, "b_oe",  b_oe,  ebe);
    endtask

    // one cycle: inputs set earlier, one rising edge, then compare
    task automatic step(input string req);
        @(negedge clk);
        #1;
        compare_all(req);
    endtask

    task automatic all_idle();
        ce_ab_n = '1; le_ab_n = '1; oe_ab_n = '1;
        ce_ba_n = '1; le_ba_n = '1; oe_ba_n = '1;
    endtask

    task automatic t_reset();
        all_idle();
        a_in = 16'hA5C3; b_in = 16'h3C5A;
        rst_n = 1'b0;
        step("R9");
        rst_n = 1'b1;
        step("R9");
        ce_ab_n[0] = 1'b0; oe_ab_n[0] = 1'b0;   // stored path, latch closed
        ce_ba_n[1] = 1'b0; oe_ba_n[1] = 1'b0;
        step("R9");
        chk("R9", "b_out cleared store", b_out, 16'h0000);
        all_idle();
    endtask

    task automatic t_ab_flow();
        ce_ab_n[0] = 1'b0; le_ab_n[0] = 1'b0; oe_ab_n[0] = 1'b0;
        a_in = 16'h0011; step("R1");
        a_in = 16'h00FE; #1 compare_all("R1");
        a_in = 16'h0080; step("R2");
        le_ab_n[0] = 1'b1; step("R2");
        a_in = 16'h0033; step("R5");
        chk("R5", "b_out kept", b_out, 16'h0080);
        a_in = 16'h00C7; step("R5");
        all_idle();
    endtask

    task automatic t_gate();
        ce_ab_n[0] = 1'b1; le_ab_n[0] = 1'b0; oe_ab_n[0] = 1'b0;
        a_in = 16'h0055; step("R3");
        le_ab_n[0] = 1'b1; step("R3");
        le_ab_n[0] = 1'b0; a_in = 16'h00AA; step("R3");
        ce_ab_n[0] = 1'b0; le_ab_n[0] = 1'b1; step("R3");
        chk("R3", "b_out after gate high", b_out, 16'h0080);
        all_idle();
    endtask

    task automatic t_oe_indep();
        ce_ab_n[1] = 1'b0; le_ab_n[1] = 1'b0; oe_ab_n[1] = 1'b1;
        a_in = 16'h6900; step("R6");
        le_ab_n[1] = 1'b1; a_in = 16'h1200; step("R6");
        oe_ab_n[1] = 1'b0; step("R6");
        chk("R6", "b_out late drive", b_out, 16'h6900);
        oe_ab_n[1] = 1'b1; step("R6");
        oe_ab_n[1] = 1'b0; step("R6");
        all_idle();
    endtask

    task automatic t_ba();
        ce_ba_n[1] = 1'b0; le_ba_n[1] = 1'b0; oe_ba_n[1] = 1'b0;
        b_in = 16'h4D00; step("R7");
        b_in = 16'hB200; step("R7");
        le_ba_n[1] = 1'b1; step("R7");
        b_in = 16'h0F00; step("R7");
        chk("R7", "a_out kept", a_out, 16'hB200);
        ce_ba_n[1] = 1'b1; le_ba_n[1] = 1'b0; step("R7");
        ce_ba_n[1] = 1'b0; le_ba_n[1] = 1'b1; step("R7");
        all_idle();
    endtask

    task automatic t_sections();
        ce_ab_n = 2'b00; oe_ab_n = 2'b00; le_ab_n = 2'b10;
        a_in = 16'hE71D; step("R8");
        a_in = 16'h19E2; step("R8");
        chk("R8", "b_out split", b_out, 16'h69E2);
        le_ab_n = 2'b01; a_in = 16'h5A5A; step("R8");
        all_idle();
    endtask

    task automatic t_both();
        ce_ab_n[0] = 1'b0; le_ab_n[0] = 1'b0;
        ce_ba_n[0] = 1'b0; le_ba_n[0] = 1'b0;
        a_in = 16'h0021; b_in = 16'h0042; step("R10");
        le_ab_n[0] = 1'b1; le_ba_n[0] = 1'b1;
        oe_ab_n[0] = 1'b0; oe_ba_n[0] = 1'b0;
        a_in = 16'h0000; b_in = 16'h00FF; step("R10");
        chk("R10", "a_out", a_out, 16'h0042);
        chk("R10", "b_out", b_out, 16'h0021);
        chk("R10", "contention seen", (clashes > 0) ? 16'h1 : 16'h0, 16'h1);
        all_idle();
        step("R4");
    endtask

    initial begin
        t_reset();
        t_ab_flow();
        t_gate();
        t_oe_indep();
        t_ba();
        t_sections();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule